// File: doc/BRIEF.md
# ARINC 429 Bipolar Transmit Serializer

This block takes 32-bit entries from a transmit buffer that sits beside it and sends each one as a 32-bit ARINC 429 frame. The frame goes out on a pair of complementary return-to-zero lines. Each bit time is split into two equal halves. In the first half one of the two lines is driven high to carry the bit value. In the second half both lines rest low. After the last bit of a frame, a quiet gap lasting four bit times follows. Timing is counted in cycles of the data clock. A speed select picks a half-bit of 5 cycles, or a slow half-bit of 40 cycles.

Bits 1 to 31 of a frame are the low 31 bits of the buffer entry, sent least significant first. Bit 32 is sent last. It is either a computed parity bit or the top bit of the entry, as set by a forcing input and an enable input. The parity sense is selectable, odd or even.

The serializer runs while its enable input is high. It pulls words from the buffer back to back until the buffer is empty, then goes idle and raises a ready flag. If enable drops in the middle of a word, that word is abandoned at once.

Top module: `a429_tx_serializer`

## Requirements
- R1: After reset, both lines are low, `buf_pop` is low, and `tx_ready` equals `buf_empty`.
- R2: With `speed_low`=0, each bit drives its line for 5 cycles and then holds both lines low for 5 cycles.
- R3: With `speed_low`=1, each bit drives its line for 40 cycles and then holds both lines low for 40 cycles.
- R4: Between two back-to-back frames, both lines stay low for the null half of bit 32 plus a gap of four bit times. That is 45 cycles at high speed and 360 cycles at low speed. Then bit 1 of the next frame starts.
- R5: When `tx_enable` rises with the buffer non-empty, the first data half appears on the lines within 2.5 clock cycles.
- R6: Frame bit k (k = 1..31) carries `buf_word[k-1]`, and bit 32 is sent last. A one drives `line_a` high and `line_b` low. A zero drives `line_b` high and `line_a` low. The two lines are never high together.
- R7: When `par_force`=1, or `par_en`=1, bit 32 is parity over `buf_word[30:0]`. `par_even`=0 makes the total count of ones in the 32-bit frame odd, and `par_even`=1 makes it even.
- R8: When `par_force`=0 and `par_en`=0, bit 32 carries `buf_word[31]`.
- R9: `buf_pop` pulses for one cycle for each word taken. The word is captured from `buf_word` in that cycle. `buf_pop` is only asserted while `tx_enable`=1 and `buf_empty`=0.
- R10: `tx_ready` is high only when the block is idle and the buffer is empty. It is low while a frame or a gap is in progress.
- R11: If `tx_enable` falls during a frame, both lines are low from the next cycle on. The word is lost, and the next enable starts a fresh frame from the next buffer entry.
- R12: Speed and parity controls are captured when a word is taken. Changing them during that word does not alter its bits or its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Run enable; low aborts the current word |
| speed_low | input | 1 | 1 selects the 40-cycle half-bit, 0 selects the 5-cycle half-bit |
| par_force | input | 1 | 1 always puts parity in bit 32 |
| par_en | input | 1 | Parity select for bit 32 when `par_force`=0 |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| buf_empty | input | 1 | Transmit buffer holds no word |
| buf_word | input | 32 | Head entry of the buffer; bit 31 is the alternate bit 32 |
| buf_pop | output | 1 | Takes the head entry this cycle |
| tx_ready | output | 1 | Idle with the buffer drained |
| line_a | output | 1 | Positive return-to-zero line |
| line_b | output | 1 | Negative return-to-zero line |

## Verification
A shift register or bit index that slips shows up in the very frame being sent, as a misplaced or missing bit in the decoded line pattern. This is visible within one bit time of the slip. A miscount in the timer shows as a data or null run of the wrong length, or as a gap of the wrong length between frames. A state machine that misses the enable drop leaves a line driven on the cycle after the drop. A wrong bit-32 selection or parity sense shows only in the final bit of a frame. Those frames are decoded and compared against a parity count computed independently.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;

  // bit 32 carries parity when either control asks for it
  function automatic logic parity_wanted(input logic force_in, input logic en_in);
    return force_in | en_in;
  endfunction

  // ones_odd: reduction XOR of the 31 data bits
  function automatic logic pick_bit32(input logic ones_odd, input logic alt_bit,
                                      input logic use_par, input logic even_sense);
    logic par_bit;
    par_bit = even_sense ? ones_odd : ~ones_odd;
    return use_par ? par_bit : alt_bit;
  endfunction

endpackage

// File: rtl/a429_frame_builder.sv
module a429_frame_builder #(
  parameter int WORD_W = 31
) (
  input  logic [WORD_W:0] word_in,
  input  logic            par_force,
  input  logic            par_en,
  input  logic            par_even,
  output logic [WORD_W:0] frame_out
);
  import a429_tx_pkg::*;

  logic ones_odd;
  logic use_par;

  always_comb begin
    ones_odd  = ^word_in[WORD_W-1:0];
    use_par   = parity_wanted(par_force, par_en);
    frame_out = {pick_bit32(ones_odd, word_in[WORD_W], use_par, par_even),
                 word_in[WORD_W-1:0]};
  end

endmodule

// File: rtl/a429_bit_timer.sv
module a429_bit_timer #(
  parameter int FRAME_BITS = 32,
  parameter int HI_HALF    = 5,
  parameter int LO_HALF    = 40,
  parameter int GAP_BITS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run_bits,
  input  logic run_gap,
  input  logic slow,
  output logic null_ph,
  output logic half_end,
  output logic bit_end,
  output logic frame_end,
  output logic gap_end
);
  localparam int GAP_MAX = LO_HALF * 2 * GAP_BITS;
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam int IDX_W   = $clog2(FRAME_BITS);

  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] gap_len;
  logic [IDX_W-1:0] bit_idx;

  always_comb begin
    half_len  = slow ? CNT_W'(LO_HALF) : CNT_W'(HI_HALF);
    gap_len   = slow ? CNT_W'(LO_HALF * 2 * GAP_BITS) : CNT_W'(HI_HALF * 2 * GAP_BITS);
    half_end  = run_bits && (tick == half_len - CNT_W'(1));
    bit_end   = half_end && null_ph;
    frame_end = bit_end && (bit_idx == IDX_W'(FRAME_BITS - 1));
    gap_end   = run_gap && (tick == gap_len - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick    <= '0;
      null_ph <= 1'b0;
      bit_idx <= '0;
    end else if (clear) begin
      tick    <= '0;
      null_ph <= 1'b0;
      bit_idx <= '0;
    end else if (run_bits) begin
      if (half_end) begin
        tick    <= '0;
        null_ph <= ~null_ph;
        if (frame_end)    bit_idx <= '0;
        else if (bit_end) bit_idx <= bit_idx + IDX_W'(1);
      end else begin
        tick <= tick + CNT_W'(1);
      end
    end else if (run_gap) begin
      tick <= gap_end ? '0 : tick + CNT_W'(1);
    end
  end

  AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_bits |-> (tick < half_len)); // R2
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_gap |-> (tick < gap_len)); // R4
  AST_GAP_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !clear) |=> (tick == '0 && !null_ph)); // R4

endmodule

// File: rtl/a429_rz_driver.sv
module a429_rz_driver (
  input  logic drive,
  input  logic bit_val,
  output logic line_a,
  output logic line_b
);

  always_comb begin
    line_a = drive &  bit_val;
    line_b = drive & ~bit_val;
  end

  always_comb begin
    AST_LINES_EXCLUSIVE: assert (!(line_a && line_b)); // R6
  end

endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer #(
  parameter int WORD_W   = 31,
  parameter int HI_HALF  = 5,
  parameter int LO_HALF  = 40,
  parameter int GAP_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_enable,
  input  logic          speed_low,
  input  logic          par_force,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          buf_empty,
  input  logic [WORD_W:0] buf_word,
  output logic          buf_pop,
  output logic          tx_ready,
  output logic          line_a,
  output logic          line_b
);
  import a429_tx_pkg::*;

  localparam int FRAME_BITS = WORD_W + 1;

  tx_state_e             state, state_nx;
  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame_new;
  logic                  slow_q;

  // named internal events
  logic can_load, word_load, abort_evt, timer_clear;
  logic null_ph, half_end, bit_end, frame_end, gap_end;
  logic drive;

  a429_frame_builder #(.WORD_W(WORD_W)) u_frame (
    .word_in  (buf_word),
    .par_force(par_force),
    .par_en   (par_en),
    .par_even (par_even),
    .frame_out(frame_new)
  );

  a429_bit_timer #(
    .FRAME_BITS(FRAME_BITS), .HI_HALF(HI_HALF),
    .LO_HALF(LO_HALF), .GAP_BITS(GAP_BITS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (timer_clear),
    .run_bits (state == ST_SEND),
    .run_gap  (state == ST_GAP),
    .slow     (slow_q),
    .null_ph  (null_ph),
    .half_end (half_end),
    .bit_end  (bit_end),
    .frame_end(frame_end),
    .gap_end  (gap_end)
  );

  always_comb begin
    can_load    = tx_enable && !buf_empty;
    abort_evt   = !tx_enable && (state != ST_IDLE);
    word_load   = can_load && ((state == ST_IDLE) || (state == ST_GAP && gap_end));
    timer_clear = word_load || (state == ST_IDLE);
    state_nx    = state;
    case (state)
      ST_IDLE: if (word_load) state_nx = ST_SEND;
      ST_SEND: begin
        if (abort_evt)      state_nx = ST_IDLE;
        else if (frame_end) state_nx = ST_GAP;
      end
      ST_GAP: begin
        if (abort_evt)      state_nx = ST_IDLE;
        else if (gap_end)   state_nx = word_load ? ST_SEND : ST_IDLE;
      end
      default:              state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      slow_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (word_load) begin
        shreg  <= frame_new;
        slow_q <= speed_low;
      end else if (bit_end) begin
        shreg  <= {1'b0, shreg[FRAME_BITS-1:1]};
      end
    end
  end

  assign drive    = (state == ST_SEND) && !null_ph;
  assign buf_pop  = word_load;
  assign tx_ready = (state == ST_IDLE) && buf_empty;

  a429_rz_driver u_rz (
    .drive  (drive),
    .bit_val(shreg[0]),
    .line_a (line_a),
    .line_b (line_b)
  );

  AST_POP_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> (tx_enable && !buf_empty)); // R9
  AST_ABORT_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!line_a && !line_b)); // R11
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!line_a && !line_b)); // R10
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (!line_a && !line_b && !tx_ready)); // R4
  AST_LOAD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && parity_wanted(par_force, par_en)) |=> ((^shreg) == !$past(par_even))); // R7
  AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && !word_load) |=> $stable(slow_q)); // R12
  AST_SHIFT_ONLY_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && !bit_end && !word_load) |=> $stable(shreg)); // R6

endmodule

// File: tb/a429_tx_serializer_test.sv
`timescale 1ns/1ps
module a429_tx_serializer_test;
  localparam int HI = 5;
  localparam int LO = 40;
  localparam int GB = 4;

  // {speed_low, par_force, par_en, par_even, word[31:0]}
  localparam logic [35:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0001},
    {1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_0001},
    {1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0000},
    {1'b0, 1'b0, 1'b0, 1'b1, 32'h7FFF_FFFF},
    {1'b0, 1'b0, 1'b1, 1'b1, 32'h2AAA_AAAA},
    {1'b0, 1'b1, 1'b1, 1'b0, 32'h5555_5555},
    {1'b1, 1'b1, 1'b0, 1'b0, 32'h1234_5678},
    {1'b1, 1'b0, 1'b0, 1'b0, 32'hC0DE_0F0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_enable = 1'b0, speed_low = 1'b0, par_force = 1'b0, par_en = 1'b0, par_even = 1'b0;
  logic buf_pop, tx_ready, line_a, line_b;
  logic [31:0] fmem [16];
  logic [3:0]  wr_ptr = 4'd0;
  logic [3:0]  rd_ptr = 4'd0;
  logic        buf_empty;
  logic [31:0] buf_word;
  int          pop_cnt = 0;
  int          nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  assign buf_empty = (wr_ptr == rd_ptr);
  assign buf_word  = fmem[rd_ptr];

  a429_tx_serializer uut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .speed_low(speed_low),
    .par_force(par_force), .par_en(par_en), .par_even(par_even),
    .buf_empty(buf_empty), .buf_word(buf_word), .buf_pop(buf_pop),
    .tx_ready(tx_ready), .line_a(line_a), .line_b(line_b)
  );

  always @(posedge clk) if (buf_pop) begin
    rd_ptr  <= rd_ptr + 4'd1;
    pop_cnt <= pop_cnt + 1;
  end

  // line decoder
  logic [31:0] mon_frame = '0, last_frame = '0;
  int mon_nbits = 0, frames_done = 0, zero_run = 0, data_run = 0, gap_run = 0;
  int dmin = 0, dmax = 0, nmin = 0, nmax = 0, cdmin = 0, cdmax = 0, cnmin = 0, cnmax = 0;
  bit in_data = 0, bitval = 0, both_high = 0;
  int mon_clr_req = 0, mon_clr_seen = 0;

  always @(negedge clk) begin
    if (mon_clr_req != mon_clr_seen) begin
      mon_clr_seen = mon_clr_req;
      mon_nbits = 0; in_data = 0; zero_run = 0; data_run = 0;
    end
    if (line_a || line_b) begin
      if (line_a && line_b) both_high = 1;
      if (!in_data) begin
        if (mon_nbits == 0) begin
          gap_run = zero_run; cdmin = 100000; cdmax = 0; cnmin = 100000; cnmax = 0;
        end else begin
          if (zero_run < cnmin) cnmin = zero_run;
          if (zero_run > cnmax) cnmax = zero_run;
        end
        in_data = 1; data_run = 0; bitval = line_a;
      end
      data_run++;
    end else begin
      if (in_data) begin
        in_data = 0;
        if (data_run < cdmin) cdmin = data_run;
        if (data_run > cdmax) cdmax = data_run;
        mon_frame[mon_nbits] = bitval;
        mon_nbits++;
        if (mon_nbits == 32) begin
          last_frame = mon_frame;
          dmin = cdmin; dmax = cdmax; nmin = cnmin; nmax = cnmax;
          frames_done++;
          mon_nbits = 0;
        end
        zero_run = 0;
      end
      zero_run++;
    end
  end

  function automatic logic [31:0] exp_frame(input logic [31:0] w, input logic frc,
                                            input logic pe, input logic ev);
    int   ones;
    logic b;
    ones = $countones(w[30:0]);
    if (frc || pe) b = ev ? ((ones % 2) == 1) : ((ones % 2) == 0);
    else           b = w[31];
    return {b, w[30:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    fmem[wr_ptr] = w;
    wr_ptr = wr_ptr + 4'd1;
  endtask

  task automatic wait_frames(input int target);
    int guard = 0;
    while (frames_done < target && guard < 20000) begin @(posedge clk); guard++; end
    check(frames_done >= target, "R6", "frame timeout", frames_done, target);
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (!tx_ready && guard < 5000) begin @(negedge clk); guard++; end
    check(tx_ready, "R10", "ready after drain", tx_ready, 1);
  endtask

  initial begin
    int base, lat, exp_pops, bad;
    logic [35:0] v;
    logic [31:0] w;
    exp_pops = 0;
    repeat (3) @(negedge clk);
    check(tx_ready == 1'b1, "R1", "ready in reset", tx_ready, 1);
    check({line_a, line_b} == 2'b00, "R1", "lines in reset", {line_a, line_b}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pop_cnt == 0 && !line_a && !line_b, "R1", "quiet after reset", pop_cnt, 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      @(negedge clk);
      speed_low = v[35]; par_force = v[34]; par_en = v[33]; par_even = v[32];
      push(v[31:0]);
      exp_pops++;
      base = frames_done;
      tx_enable = 1'b1;
      @(negedge clk);
      check(!tx_ready, "R10", "ready low while sending", tx_ready, 0);
      wait_frames(base + 1);
      check(last_frame == exp_frame(v[31:0], v[34], v[33], v[32]),
            (v[34] || v[33]) ? "R7" : "R8", "frame", last_frame,
            exp_frame(v[31:0], v[34], v[33], v[32]));
      check(dmin == (v[35] ? LO : HI) && dmax == dmin, v[35] ? "R3" : "R2",
            "data half length", dmax, v[35] ? LO : HI);
      check(nmin == (v[35] ? LO : HI) && nmax == nmin, v[35] ? "R3" : "R2",
            "null half length", nmax, v[35] ? LO : HI);
      wait_ready();
      check(pop_cnt == exp_pops, "R9", "one pop per word", pop_cnt, exp_pops);
      @(negedge clk);
      tx_enable = 1'b0;
    end

    // R4 gap at both speeds
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      speed_low = (s == 1); par_force = 1'b1; par_en = 1'b0; par_even = 1'b0;
      push(32'h0000_00F1); push(32'h0F00_0A0A);
      exp_pops += 2;
      base = frames_done;
      tx_enable = 1'b1;
      wait_frames(base + 2);
      check(gap_run == (s == 1 ? LO + GB * 2 * LO : HI + GB * 2 * HI), "R4",
            "quiet run between frames", gap_run, (s == 1 ? LO + GB * 2 * LO : HI + GB * 2 * HI));
      check(last_frame == exp_frame(32'h0F00_0A0A, 1'b1, 1'b0, 1'b0), "R4",
            "second frame", last_frame, exp_frame(32'h0F00_0A0A, 1'b1, 1'b0, 1'b0));
      wait_ready();
      @(negedge clk);
      tx_enable = 1'b0;
    end

    // R5 latency from enable to first data half
    @(negedge clk);
    speed_low = 1'b0; par_force = 1'b1;
    push(32'h0000_0002);
    exp_pops++;
    base = frames_done;
    tx_enable = 1'b1;
    lat = 0;
    while (!(line_a || line_b) && lat < 10) begin @(negedge clk); lat++; end
    check(lat <= 2, "R5", "cycles to first data half", lat, 2);
    check(line_b && !line_a, "R6", "first bit is zero on line_b", {line_a, line_b}, 2'b01);
    wait_frames(base + 1);
    wait_ready();
    @(negedge clk);
    tx_enable = 1'b0;

    // R11 abort mid-word
    @(negedge clk);
    push(32'h0000_FFFF); push(32'h0000_0005);
    exp_pops++;
    base = frames_done;
    tx_enable = 1'b1;
    while (mon_nbits < 3) @(posedge clk);
    @(negedge clk);
    tx_enable = 1'b0;
    @(negedge clk);
    check(!line_a && !line_b, "R11", "lines after enable drop", {line_a, line_b}, 0);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (line_a || line_b || tx_ready) bad++;
    end
    check(bad == 0, "R11", "quiet and not ready while word pending", bad, 0);
    check(pop_cnt == exp_pops, "R11", "only aborted word taken", pop_cnt, exp_pops);
    mon_clr_req++;
    @(negedge clk);
    exp_pops++;
    tx_enable = 1'b1;
    wait_frames(base + 1);
    check(last_frame == exp_frame(32'h0000_0005, 1'b1, 1'b0, 1'b0), "R11",
          "next word after abort", last_frame, exp_frame(32'h0000_0005, 1'b1, 1'b0, 1'b0));
    wait_ready();
    @(negedge clk);
    tx_enable = 1'b0;

    // R12 controls changed mid-word
    @(negedge clk);
    speed_low = 1'b0; par_force = 1'b1; par_en = 1'b0; par_even = 1'b0;
    w = 32'h0000_0003;
    push(w);
    exp_pops++;
    base = frames_done;
    tx_enable = 1'b1;
    while (mon_nbits < 2) @(posedge clk);
    @(negedge clk);
    speed_low = 1'b1; par_force = 1'b0; par_even = 1'b1;
    wait_frames(base + 1);
    check(last_frame == exp_frame(w, 1'b1, 1'b0, 1'b0), "R12", "frame uses captured controls",
          last_frame, exp_frame(w, 1'b1, 1'b0, 1'b0));
    check(dmax == HI && nmax == HI, "R12", "speed held for word", dmax, HI);
    wait_ready();
    check(pop_cnt == exp_pops, "R9", "total pops", pop_cnt, exp_pops);
    check(!both_high, "R6", "lines never high together", both_high, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end

endmodule